// File: doc/BRIEF.md
# Triggered Transmit Start Delay

This block sits beside a UART transmitter and holds back the start of a serial transmission for a programmable number of bit periods. The count begins when a transmit trigger pulse arrives. Software programs a 16-bit delay value through two byte-wide read/write registers on a simple register bus. An external baud generator supplies a bit-tick pulse once per bit period. The block counts those ticks, not system clocks.

When the programmed number of bit periods has passed, the block issues a single-cycle start strobe to the transmitter. Several channels that share one trigger can therefore begin sending at instants that are fixed relative to each other. While a countdown runs, a busy flag is high and further triggers are ignored. The delay value is captured when the trigger is accepted, so software can reprogram the registers for the next run without disturbing the current one.

Top module: `trig_tx_delay`

## Requirements
- R1: After reset both delay bytes read 0x00, and `tx_start` and `delay_busy` are low.
- R2: A write (`bus_wr` high) to address 0x21 sets the delay's low byte, and a write to 0x22 sets its high byte. `bus_rdata` returns the addressed byte combinationally. Any other address reads 0x00, and writes to it change nothing.
- R3: A `tx_trig` pulse while idle captures the delay value D = {byte 0x22, byte 0x21} and raises `delay_busy` at the next clock edge. A `bit_tick` in the trigger cycle itself is not counted.
- R4: `tx_start` is high for exactly one clock, in the cycle after the (D+1)-th `bit_tick` counted from the cycle after the trigger. `delay_busy` falls in that same cycle.
- R5: With D = 0, the first `bit_tick` after the trigger produces the strobe.
- R6: Register writes made during a countdown, including a write in the same cycle as the accepted trigger, do not change that countdown. They are still visible on read-back.
- R7: A `tx_trig` that arrives while `delay_busy` is high is ignored. No extra strobe follows and the timing of the pending strobe does not change.
- R8: `bit_tick` pulses while idle produce no strobe.
- R9: The largest delay, D = 65535, produces the strobe on the 65536th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on `bus_addr`) |
| bit_tick | input | 1 | One-clock pulse once per bit period |
| tx_trig | input | 1 | Transmit trigger pulse |
| tx_start | output | 1 | Single-clock start-transmission strobe |
| delay_busy | output | 1 | High while a countdown is in progress |

## Verification
The assertions assume that `bit_tick` and `tx_trig` are synchronous to `clk` and stable between edges. They do not require either signal to be a single-cycle pulse. A held level counts once per cycle and is still handled correctly.

The bench drives every input on the falling edge. It varies the tick spacing from back-to-back ticks up to every fourth cycle. It deliberately places triggers, register writes and ticks in the same cycle, so that the capture ordering and the rule that a busy trigger is ignored are both exercised at their boundaries.

// File: rtl/trig_dly_pkg.sv
package trig_dly_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tdly_regs.sv
module tdly_regs
   import trig_dly_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DELAY_W   = 16,
   parameter int BASE_ADDR = 'h21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  byte_t              wdata,
   output byte_t              rdata,
   output logic [DELAY_W-1:0] delay_val
);
   localparam int NBYTES = DELAY_W / BYTE_W;

   byte_t [NBYTES-1:0] bytes_q;
   logic  [NBYTES-1:0] hit;

   generate
      if ((DELAY_W % BYTE_W) != 0 || DELAY_W < BYTE_W) begin : g_bad_width
         $error("DELAY_W must be a non-zero multiple of the byte width");
      end
      if (BASE_ADDR + NBYTES > (1 << ADDR_W)) begin : g_bad_addr
         $error("register window exceeds the address space");
      end
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign hit[b] = (addr == ADDR_W'(BASE_ADDR + b));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                bytes_q[b] <= '0;
            else if (wr_en && hit[b])  bytes_q[b] <= wdata;
         end
         // R2: a write lands in the addressed byte
         assert_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && hit[b] |=> bytes_q[b] == $past(wdata));
         // R2: an unaddressed byte keeps its value
         assert_byte_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && hit[b]) |=> $stable(bytes_q[b]));
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NBYTES; b++)
         if (hit[b]) rdata = bytes_q[b];
   end

   assign delay_val = bytes_q;

   // R2: at most one byte decodes any address
   assert_decode_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/tdly_count.sv
module tdly_count #(
   parameter int DELAY_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig,
   input  logic               tick,
   input  logic [DELAY_W-1:0] load_val,
   output logic               start_o,
   output logic               busy_o
);
   logic [DELAY_W-1:0] cnt_q;
   logic               busy_q, start_q;
   logic               at_end, fire;

   assign at_end = (cnt_q == '0);
   assign fire   = busy_q & tick & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= fire;
         if (busy_q) begin
            if (tick) begin
               if (at_end) busy_q <= 1'b0;
               else        cnt_q  <= cnt_q - 1'b1;
            end
         end else if (trig) begin
            cnt_q  <= load_val;
            busy_q <= 1'b1;
         end
      end
   end

   assign start_o = start_q;
   assign busy_o  = busy_q;

   // R3: an idle trigger captures the value presented at the trigger edge
   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q && trig |=> busy_q && cnt_q == $past(load_val));
   // R4: strobe lasts a single clock
   assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   // R4: the count ends only together with a strobe
   assert_end_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> start_q);
   // R6/R7: without a tick the count is frozen, whatever writes or triggers occur
   assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !tick |=> busy_q && $stable(cnt_q));
   // R8: no strobe can follow an idle cycle
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |=> !start_q);
endmodule

// File: rtl/trig_tx_delay.sv
module trig_tx_delay
   import trig_dly_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DELAY_W   = 16,
   parameter int BASE_ADDR = 'h21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              bit_tick,
   input  logic              tx_trig,
   output logic              tx_start,
   output logic              delay_busy
);
   logic [DELAY_W-1:0] delay_val;

   tdly_regs #(
      .ADDR_W   (ADDR_W),
      .DELAY_W  (DELAY_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .delay_val(delay_val)
   );

   tdly_count #(
      .DELAY_W(DELAY_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (tx_trig),
      .tick    (bit_tick),
      .load_val(delay_val),
      .start_o (tx_start),
      .busy_o  (delay_busy)
   );

   // R4: when the strobe is out, the channel is already idle
   assert_idle_at_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !delay_busy);
   // R7: a busy trigger never starts a fresh count on its own
   assert_busy_trig_R7: assert property (@(posedge clk) disable iff (!rst_n)
      delay_busy && tx_trig && !bit_tick |=> delay_busy);
endmodule

// File: tb/tb_trig_tx_delay.sv
module tb_trig_tx_delay;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       bit_tick = 1'b0;
   logic       tx_trig = 1'b0;
   logic       tx_start, delay_busy;

   int checks = 0;
   int fails = 0;
   int strobes = 0;

   // reference model state
   logic [7:0]  m_lo = 8'h00, m_hi = 8'h00;
   logic        m_busy = 1'b0, m_start = 1'b0;
   int unsigned m_cnt = 0;

   always #5 clk = ~clk;

   trig_tx_delay dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_tick(bit_tick),
      .tx_trig(tx_trig), .tx_start(tx_start), .delay_busy(delay_busy)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural model, advanced on every clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_lo = 0; m_hi = 0; m_busy = 0; m_start = 0; m_cnt = 0;
      end else begin
         m_start = 1'b0;
         if (m_busy) begin
            if (bit_tick) begin
               if (m_cnt == 0) begin m_start = 1'b1; m_busy = 1'b0; end
               else m_cnt = m_cnt - 1;
            end
         end else if (tx_trig) begin
            m_cnt  = {m_hi, m_lo};
            m_busy = 1'b1;
         end
         if (bus_wr && bus_addr == 8'h21) m_lo = bus_wdata;
         if (bus_wr && bus_addr == 8'h22) m_hi = bus_wdata;
      end
   end

   // comparison away from the edge
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         logic [7:0] exp_rd;
         exp_rd = (bus_addr == 8'h21) ? m_lo : (bus_addr == 8'h22) ? m_hi : 8'h00;
         chk(tx_start == m_start, "R4 tx_start", tx_start, m_start);
         chk(delay_busy == m_busy, "R3 delay_busy", delay_busy, m_busy);
         chk(bus_rdata == exp_rd, "R2 bus_rdata", bus_rdata, exp_rd);
         if (tx_start) strobes++;
      end
   end

   task automatic drive(input logic wr, input logic [7:0] a, input logic [7:0] d,
                        input logic tk, input logic tg);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; bit_tick = tk; tx_trig = tg;
   endtask

   task automatic idle();
      drive(1'b0, bus_addr, 8'h00, 1'b0, 1'b0);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      drive(1'b1, a, d, 1'b0, 1'b0);
      idle();
   endtask

   // tick every (gap+1) cycles until a strobe is seen; returns the tick count
   task automatic tick_until_strobe(input int gap, input int limit, output int n);
      int s0;
      s0 = strobes;
      n = 0;
      while (strobes == s0 && n < limit) begin
         drive(1'b0, bus_addr, 8'h00, 1'b1, 1'b0);
         n++;
         @(posedge clk); #3;
         for (int g = 0; g < gap && strobes == s0; g++) idle();
      end
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n, s0;
      // R1: reset values
      bus_addr = 8'h21;
      repeat (3) @(posedge clk);
      #2;
      chk(bus_rdata == 8'h00, "R1 low byte in reset", bus_rdata, 0);
      chk(tx_start == 1'b0, "R1 strobe in reset", tx_start, 0);
      chk(delay_busy == 1'b0, "R1 busy in reset", delay_busy, 0);
      @(negedge clk); bus_addr = 8'h22; @(posedge clk); #2;
      chk(bus_rdata == 8'h00, "R1 high byte in reset", bus_rdata, 0);
      @(negedge clk); rst_n = 1'b1;
      idle();

      // R2: register access and unmapped address
      wr_reg(8'h21, 8'h03);
      wr_reg(8'h22, 8'h00);
      wr_reg(8'h30, 8'h55);
      drive(1'b0, 8'h30, 8'h00, 1'b0, 1'b0); @(posedge clk); #3;
      chk(bus_rdata == 8'h00, "R2 unmapped read", bus_rdata, 0);
      drive(1'b0, 8'h21, 8'h00, 1'b0, 1'b0); @(posedge clk); #3;
      chk(bus_rdata == 8'h03, "R2 low byte readback", bus_rdata, 8'h03);

      // R3/R4: delay 3 with a tick in the trigger cycle (not counted), sparse ticks
      drive(1'b0, 8'h21, 8'h00, 1'b1, 1'b1);
      idle();
      tick_until_strobe(2, 100, n);
      chk(n == 4, "R4 ticks for delay 3", n, 4);

      // R5: zero delay
      wr_reg(8'h21, 8'h00);
      drive(1'b0, 8'h21, 8'h00, 1'b0, 1'b1);
      idle();
      tick_until_strobe(0, 100, n);
      chk(n == 1, "R5 zero delay ticks", n, 1);

      // R6: write in the trigger cycle and during the count
      wr_reg(8'h21, 8'h05);
      drive(1'b1, 8'h21, 8'h02, 1'b0, 1'b1);
      idle();
      wr_reg(8'h22, 8'h01);
      tick_until_strobe(1, 1000, n);
      chk(n == 6, "R6 countdown uses captured value", n, 6);
      drive(1'b0, 8'h22, 8'h00, 1'b0, 1'b0); @(posedge clk); #3;
      chk(bus_rdata == 8'h01, "R6 write visible on readback", bus_rdata, 1);
      wr_reg(8'h22, 8'h00);

      // R7: second trigger while busy
      wr_reg(8'h21, 8'h04);
      s0 = strobes;
      drive(1'b0, 8'h21, 8'h00, 1'b0, 1'b1);
      idle();
      drive(1'b0, 8'h21, 8'h00, 1'b1, 1'b0);
      drive(1'b0, 8'h21, 8'h00, 1'b0, 1'b1);
      drive(1'b0, 8'h21, 8'h00, 1'b1, 1'b1);
      idle();
      tick_until_strobe(3, 100, n);
      chk(n == 3, "R7 remaining ticks after busy trigger", n, 3);
      repeat (20) drive(1'b0, 8'h21, 8'h00, 1'b1, 1'b0);
      idle(); @(posedge clk); #3;
      chk(strobes - s0 == 1, "R7 single strobe", strobes - s0, 1);

      // R8: idle ticks do nothing
      s0 = strobes;
      repeat (10) drive(1'b0, 8'h21, 8'h00, 1'b1, 1'b0);
      idle(); idle(); @(posedge clk); #3;
      chk(strobes == s0, "R8 no strobe when idle", strobes - s0, 0);
      chk(delay_busy == 1'b0, "R8 stays idle", delay_busy, 0);

      // R9: maximum delay with a tick every cycle
      wr_reg(8'h21, 8'hFF);
      wr_reg(8'h22, 8'hFF);
      drive(1'b0, 8'h21, 8'h00, 1'b0, 1'b1);
      idle();
      tick_until_strobe(0, 70000, n);
      chk(n == 65536, "R9 maximum delay ticks", n, 65536);

      repeat (3) idle();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule